// File: doc/BRIEF.md
# Clocked Serial Slave Receiver

This block receives characters from an external serial master that drives both a shift clock and a data line. The shift clock is brought into the system clock domain through a synchronizer. On each rising edge of that clock one data bit is taken, least significant bit first. When a character is complete it moves into a two-entry receive FIFO. While the FIFO holds data, a receive flag is raised, and an interrupt request can be raised with it.

Characters are 8 or 9 bits long. In 9-bit mode the extra bit is stored beside its FIFO entry and is shown on its own output. A read strobe pops the data byte and its ninth bit together.

The port only receives when all four of these hold: it is enabled, it is in synchronous mode, the external clock source is selected, and continuous receive is on. If a character completes while the FIFO is full, an overrun is flagged and latched. Only dropping continuous receive or the port enable clears it.

Top module: `sync_slave_rx`

## Requirements
- R1: Shift-clock edges are taken only when port_en=1, sync_mode=1, clk_src_master=0 and cont_rx_en=1; if any of these does not hold, no character is received.
- R2: A data bit is sampled on each rising edge of ser_clk, first bit into data bit 0. In 8-bit mode a character is complete after 8 rising edges, and rd_ninth reads 0 for it.
- R3: With nine_bit_en=1 a character takes 9 rising edges. Its last bit appears on rd_ninth and its first 8 bits appear on rd_data.
- R4: While cont_rx_en stays 1, characters sent back to back are all received, in order.
- R5: single_rx_en has no effect on reception in any setting.
- R6: rx_flag is 1 exactly while the FIFO is not empty. rx_irq equals rx_flag AND rx_irq_en.
- R7: The FIFO holds two characters and presents the oldest one. A one-cycle rd_strobe pops the data and its ninth bit together. A read strobe while the FIFO is empty changes nothing.
- R8: A character that completes while the FIFO is full and no read is taken sets overrun and is discarded. While overrun is 1, every later character is discarded. Overrun stays 1 until cont_rx_en or port_en goes to 0.
- R9: port_en=0 empties the FIFO, clears overrun and drops any partial character.
- R10: cont_rx_en=0 drops any partial character and clears overrun, but keeps the FIFO contents.
- R11: A character that completes in the same cycle as a read of a full FIFO is stored, and overrun stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Shift clock from the external master |
| ser_data | input | 1 | Serial data from the external master |
| port_en | input | 1 | Port enable; 0 resets the receiver |
| sync_mode | input | 1 | Synchronous mode select |
| clk_src_master | input | 1 | 1 = internal clock source (master); must be 0 to receive |
| cont_rx_en | input | 1 | Continuous receive enable |
| single_rx_en | input | 1 | Single receive enable (no effect in slave mode) |
| nine_bit_en | input | 1 | Select 9-bit characters |
| rx_irq_en | input | 1 | Receive interrupt enable |
| rd_strobe | input | 1 | One-cycle pulse that pops the FIFO head |
| rd_data | output | 8 | Low 8 bits of the FIFO head (0 when empty) |
| rd_ninth | output | 1 | Ninth bit of the FIFO head (0 when empty) |
| rx_flag | output | 1 | FIFO not empty |
| rx_irq | output | 1 | Receive interrupt request |
| overrun | output | 1 | Latched overrun error |

## Verification
Two events can fall in the same cycle: a character completing while the FIFO is full, and a read that frees a slot. The bench counts the synchronizer and shifter registers so that its read strobe lands on the very cycle the third character is written. It then judges the result by three checks: overrun must stay 0, the head must have moved to the second character, and the third character must follow it. A second case sends a third character with no read, to show that the same completion does raise overrun.

// File: rtl/sync_rx_pkg.sv
// Package: shared width and FIFO entry type for the clocked serial slave receiver.
// Assumes: characters are at most DATA_W+1 bits wide.
package sync_rx_pkg;
    localparam int DATA_W = 8;

    typedef struct packed {
        logic              ninth;
        logic [DATA_W-1:0] data;
    } rx_entry_t;
endpackage

// File: rtl/sclk_sync.sv
// Module: brings the external shift clock and data into the clk domain.
// Two flops on each line, then a third clock flop for rising-edge detection.
// Assumes: the data line is stable for at least two clk cycles around each rising clock edge.
module sclk_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk,
    input  logic ser_data,
    output logic rise,
    output logic data_s
);
    logic c1, c2, c3;
    logic d1, d2;

    // Synchronizer chains and edge-history register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c1 <= 1'b0; c2 <= 1'b0; c3 <= 1'b0;
            d1 <= 1'b0; d2 <= 1'b0;
        end else begin
            c1 <= ser_clk; c2 <= c1; c3 <= c2;
            d1 <= ser_data; d2 <= d1;
        end
    end

    // Rising edge seen in the synchronized clock.
    assign rise   = c2 & ~c3;
    assign data_s = d2;

    a_r2_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/rx_shifter.sv
// Module: collects serial bits, LSB first, into a character of 8 or 9 bits.
// Pulses done for one cycle with the finished word; clears all state while not enabled.
// Assumes: rise is never high on two consecutive cycles.
module rx_shifter
    import sync_rx_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      enable,
    input  logic      nine_bit,
    input  logic      rise,
    input  logic      din,
    output logic      done,
    output rx_entry_t word
);
    localparam int CNT_W = $clog2(W + 2);

    logic [W:0]       sr_q, sr_n;
    logic [CNT_W-1:0] bit_cnt;
    logic [CNT_W-1:0] last_idx;

    // Index of the final bit for the selected character length.
    assign last_idx = nine_bit ? CNT_W'(W) : CNT_W'(W - 1);

    // Next shift-register value with the incoming bit placed at its position.
    always_comb begin
        sr_n = sr_q;
        for (int i = 0; i <= W; i++) begin
            if (CNT_W'(i) == bit_cnt) sr_n[i] = din;
        end
    end

    // Bit counter, shift register and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            sr_q    <= '0;
            bit_cnt <= '0;
            done    <= 1'b0;
            word    <= '0;
        end else begin
            done <= 1'b0;
            if (rise) begin
                if (bit_cnt == last_idx) begin
                    done       <= 1'b1;
                    word.data  <= sr_n[W-1:0];
                    word.ninth <= nine_bit & sr_n[W];
                    sr_q       <= '0;
                    bit_cnt    <= '0;
                end else begin
                    sr_q    <= sr_n;
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    a_r10_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (bit_cnt == '0 && !done));
    a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/rx_fifo.sv
// Module: small circular receive FIFO of rx_entry_t words with a level count.
// A pop on an empty FIFO is ignored. A push and a pop in the same cycle on a full FIFO are both taken.
// Assumes: the caller never pushes into a full FIFO without also popping.
module rx_fifo
    import sync_rx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push,
    input  rx_entry_t                  wdata,
    input  logic                       pop,
    output rx_entry_t                  head,
    output logic [$clog2(DEPTH+1)-1:0] level
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = $clog2(DEPTH + 1);

    rx_entry_t        mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_pop;

    assign do_pop = pop && (level != '0);

    // Pointer advance with wrap at DEPTH.
    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Storage write.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wdata;
    end

    // Pointers and level.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push)   wr_ptr <= nxt(wr_ptr);
            if (do_pop) rd_ptr <= nxt(rd_ptr);
            level <= level + LVL_W'(push) - LVL_W'(do_pop);
        end
    end

    // Head presented only while the FIFO holds data.
    assign head = (level != '0) ? mem[rd_ptr] : '0;

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));
    a_r7_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && level == '0 && !push && !flush) |=> level == '0);
endmodule

// File: rtl/sync_slave_rx.sv
// Module: clocked serial slave receiver top. Ties together the synchronizer, shifter and FIFO,
// the overrun latch and the flag and interrupt outputs.
// Assumes: rd_strobe is one clk cycle per read; the master's clock is much slower than clk.
module sync_slave_rx
    import sync_rx_pkg::*;
#(
    parameter int FIFO_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              port_en,
    input  logic              sync_mode,
    input  logic              clk_src_master,
    input  logic              cont_rx_en,
    input  logic              single_rx_en,
    input  logic              nine_bit_en,
    input  logic              rx_irq_en,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_ninth,
    output logic              rx_flag,
    output logic              rx_irq,
    output logic              overrun
);
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

    logic             rise, data_s, done, active, fifo_full, push;
    logic             unused_single;
    rx_entry_t        word, head;
    logic [LVL_W-1:0] level;

    // Single receive has no role in slave mode.
    assign unused_single = single_rx_en;

    // Receiver runs only in enabled synchronous slave mode with continuous receive on.
    assign active = port_en & sync_mode & ~clk_src_master & cont_rx_en;

    sclk_sync i_sync (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .rise(rise), .data_s(data_s)
    );

    rx_shifter #(.W(DATA_W)) i_shift (
        .clk(clk), .rst_n(rst_n), .enable(active), .nine_bit(nine_bit_en),
        .rise(rise), .din(data_s), .done(done), .word(word)
    );

    // A finished character is stored unless overrun is latched or the FIFO stays full.
    assign fifo_full = (level == LVL_W'(FIFO_DEPTH));
    assign push      = done & ~overrun & (~fifo_full | rd_strobe);

    rx_fifo #(.DEPTH(FIFO_DEPTH)) i_fifo (
        .clk(clk), .rst_n(rst_n), .flush(~port_en), .push(push), .wdata(word),
        .pop(rd_strobe), .head(head), .level(level)
    );

    // Overrun latch: set by a character that finds no room, cleared by dropping the enables.
    always_ff @(posedge clk) begin
        if (!rst_n || !port_en || !cont_rx_en) overrun <= 1'b0;
        else if (done && fifo_full && !rd_strobe) overrun <= 1'b1;
    end

    // Status and read outputs.
    assign rd_data  = head.data;
    assign rd_ninth = head.ninth;
    assign rx_flag  = (level != '0);
    assign rx_irq   = rx_flag & rx_irq_en;

    a_r8_overrun_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && port_en && cont_rx_en) |=> overrun);
    a_r9_port_flush: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> (level == '0 && !overrun));
    a_r11_read_frees_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fifo_full && rd_strobe && !overrun && port_en && cont_rx_en) |=> (!overrun && fifo_full));
endmodule

// File: tb/test_sync_slave_rx.sv
// Directed bench: one task per scenario, each checking its own results.
module test_sync_slave_rx;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0;
    logic port_en = 1'b0, sync_mode = 1'b1, clk_src_master = 1'b0, cont_rx_en = 1'b0;
    logic single_rx_en = 1'b0, nine_bit_en = 1'b0, rx_irq_en = 1'b0, rd_strobe = 1'b0;
    logic [7:0] rd_data;
    logic rd_ninth, rx_flag, rx_irq, overrun;
    int n_checks = 0, n_errors = 0;

    always #5 clk = ~clk;

    sync_slave_rx i_sync_slave_rx (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .port_en(port_en), .sync_mode(sync_mode), .clk_src_master(clk_src_master),
        .cont_rx_en(cont_rx_en), .single_rx_en(single_rx_en), .nine_bit_en(nine_bit_en),
        .rx_irq_en(rx_irq_en), .rd_strobe(rd_strobe), .rd_data(rd_data), .rd_ninth(rd_ninth),
        .rx_flag(rx_flag), .rx_irq(rx_irq), .overrun(overrun)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FIFO-RX FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One bit: clock low with data, then rising edge. If align is set, a read lands on the storing cycle.
    task automatic send_bit(input logic b, input bit align);
        @(negedge clk); ser_clk = 1'b0; ser_data = b;
        repeat (3) @(negedge clk);
        ser_clk = 1'b1;
        if (align) begin
            repeat (3) @(posedge clk);
            @(negedge clk); rd_strobe = 1'b1;
            @(negedge clk); rd_strobe = 1'b0;
        end else begin
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic send_char(input logic [8:0] v, input int nbits, input bit align);
        for (int i = 0; i < nbits; i++) send_bit(v[i], align && (i == nbits - 1));
        repeat (4) @(negedge clk);
    endtask

    task automatic do_read;
        @(negedge clk); rd_strobe = 1'b1;
        @(negedge clk); rd_strobe = 1'b0;
    endtask

    task automatic enable_all;
        @(negedge clk); port_en = 1'b1; sync_mode = 1'b1; clk_src_master = 1'b0; cont_rx_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R6 reset flag", rx_flag, 0);
        chk("R6 reset irq", rx_irq, 0);
        chk("R8 reset overrun", overrun, 0);
        chk("R7 reset data", rd_data, 0);
    endtask

    task automatic t_basic8;
        nine_bit_en = 1'b0; rx_irq_en = 1'b0;
        send_char(9'h0A5, 8, 0);
        chk("R2 data", rd_data, 8'hA5);
        chk("R2 ninth zero", rd_ninth, 0);
        chk("R6 flag set", rx_flag, 1);
        chk("R6 irq masked", rx_irq, 0);
        @(negedge clk); rx_irq_en = 1'b1; @(negedge clk);
        chk("R6 irq enabled", rx_irq, 1);
        do_read;
        chk("R6 flag clears", rx_flag, 0);
        chk("R6 irq clears", rx_irq, 0);
    endtask

    task automatic t_nine;
        nine_bit_en = 1'b1;
        send_char(9'h13C, 9, 0);
        send_char(9'h0C3, 9, 0);
        chk("R3 low byte", rd_data, 8'h3C);
        chk("R3 ninth one", rd_ninth, 1);
        do_read;
        chk("R3 second low", rd_data, 8'hC3);
        chk("R3 second ninth", rd_ninth, 0);
        do_read;
        nine_bit_en = 1'b0;
    endtask

    task automatic t_gate;
        @(negedge clk); sync_mode = 1'b0;
        send_char(9'h055, 8, 0);
        chk("R1 async ignored", rx_flag, 0);
        @(negedge clk); sync_mode = 1'b1; clk_src_master = 1'b1;
        send_char(9'h055, 8, 0);
        chk("R1 master ignored", rx_flag, 0);
        @(negedge clk); clk_src_master = 1'b0; port_en = 1'b0;
        send_char(9'h055, 8, 0);
        chk("R1 disabled ignored", rx_flag, 0);
        @(negedge clk); port_en = 1'b1; cont_rx_en = 1'b0;
        send_char(9'h055, 8, 0);
        chk("R1 no cont ignored", rx_flag, 0);
        enable_all;
    endtask

    task automatic t_single;
        @(negedge clk); cont_rx_en = 1'b0; single_rx_en = 1'b1;
        send_char(9'h066, 8, 0);
        chk("R5 single alone ignored", rx_flag, 0);
        enable_all;
        send_char(9'h0E7, 8, 0);
        chk("R5 single no effect", rd_data, 8'hE7);
        do_read;
        chk("R5 after read", rx_flag, 0);
        single_rx_en = 1'b0;
    endtask

    task automatic t_b2b;
        do_read;
        chk("R7 empty read ignored", rx_flag, 0);
        send_char(9'h011, 8, 0);
        send_char(9'h0F0, 8, 0);
        chk("R4 first", rd_data, 8'h11);
        do_read;
        chk("R4 second", rd_data, 8'hF0);
        chk("R7 one left", rx_flag, 1);
        do_read;
        chk("R7 empty", rx_flag, 0);
        chk("R4 no overrun", overrun, 0);
    endtask

    task automatic t_overrun;
        send_char(9'h001, 8, 0);
        send_char(9'h002, 8, 0);
        chk("R8 no overrun at full", overrun, 0);
        send_char(9'h003, 8, 0);
        chk("R8 overrun set", overrun, 1);
        do_read;
        send_char(9'h004, 8, 0);
        chk("R8 head after read", rd_data, 8'h02);
        do_read;
        chk("R8 extras discarded", rx_flag, 0);
        chk("R8 overrun held", overrun, 1);
        @(negedge clk); cont_rx_en = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R10 overrun cleared", overrun, 0);
        enable_all;
        send_char(9'h077, 8, 0);
        chk("R8 receive resumes", rd_data, 8'h77);
        // R10: FIFO contents survive dropping continuous receive
        send_bit(1'b1, 0); send_bit(1'b1, 0); send_bit(1'b1, 0); send_bit(1'b1, 0);
        @(negedge clk); cont_rx_en = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R10 fifo kept", rd_data, 8'h77);
        enable_all;
        send_char(9'h05A, 8, 0);
        do_read;
        chk("R10 partial dropped", rd_data, 8'h5A);
        do_read;
    endtask

    task automatic t_port;
        send_char(9'h0AB, 8, 0);
        send_bit(1'b1, 0); send_bit(1'b0, 0); send_bit(1'b1, 0);
        @(negedge clk); port_en = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R9 fifo flushed", rx_flag, 0);
        enable_all;
        send_char(9'h03C, 8, 0);
        chk("R9 partial dropped", rd_data, 8'h3C);
        do_read;
        // R9: overrun cleared by port disable
        send_char(9'h001, 8, 0); send_char(9'h002, 8, 0); send_char(9'h003, 8, 0);
        chk("R9 overrun before", overrun, 1);
        @(negedge clk); port_en = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R9 overrun cleared", overrun, 0);
        enable_all;
    endtask

    task automatic t_same_cycle;
        send_char(9'h0A1, 8, 0);
        send_char(9'h0B2, 8, 0);
        send_char(9'h0C3, 8, 1);
        chk("R11 no overrun", overrun, 0);
        chk("R11 head advanced", rd_data, 8'hB2);
        do_read;
        chk("R11 third stored", rd_data, 8'hC3);
        do_read;
        chk("R11 empty after", rx_flag, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        enable_all;
        t_basic8;
        t_nine;
        t_gate;
        t_single;
        t_b2b;
        t_overrun;
        t_port;
        t_same_cycle;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FIFO-RX FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule